// File: doc/BRIEF.md
# Tick-Scheduled Serial Channel

This block is a half-duplex asynchronous serial channel whose bit timing comes from one compare register set against a shared 16-bit free-running counter. The counter advances once per slow tick (`tick_en`, nominally about 32.768 kHz). Each bit edge is placed on a compare match, and the compare value moves forward by a fixed bit period after each match. The transmit pin therefore changes on the same clock edge as the matching tick. No oversampling baud generator is used.

To receive, the channel is armed and waits in capture mode for a synchronized falling edge on the receive pin. The capture loads the compare register with the captured count plus one and a half bit periods. From then on the channel runs in compare mode and samples the synchronized line once per bit period. One channel handles either direction, never both at once. Requests made while it is busy are dropped.

Top module: `tick_uart`

## Requirements
- R1: The 16-bit counter increases by one on every clock with `tick_en` high, holds otherwise, and wraps from 65535 to 0.
- R2: After reset `tx_out` is 1, `busy`, `tx_done` and `rx_done` are 0 and `rx_data` is 0. `tx_out` stays 1 whenever no transmit frame is in progress.
- R3: A `tx_start` accepted while idle with the counter at C loads the compare register with C+27. The start bit appears on `tx_out` at the tick on which the counter reads C+27, so the bench sees it once C+28 ticks have counted.
- R4: The transmit frame is 10 bits in this order: a 0 start bit, the 8 bits of `tx_data` least-significant first, then a 1 stop bit.
- R5: Each compare match adds 27 ticks to the compare value, modulo 2^16. Successive bit edges on `tx_out` are therefore exactly 27 ticks apart, including across counter rollover.
- R6: The stop bit lasts one full period. At the eleventh match, `tx_done` pulses high for one clock and `busy` falls, which is 298 ticks after the accept count C.
- R7: After `rx_arm`, the channel passes `rx_in` through a two-flop synchronizer and captures its first falling edge. The first data sample is taken 27+14 ticks after the capture count. `rx_done` follows 8.5 bit periods (230 ticks) after the capture.
- R8: Eight samples are taken one bit period apart and shifted in least-significant first. The stop bit is not sampled. At the eighth sample the byte appears on `rx_data` and `rx_done` pulses for one clock.
- R9: `rx_data` holds its value until the next reception completes. Transmit frames and line activity while the channel is not armed leave it unchanged.
- R10: `tx_start` or `rx_arm` raised while `busy` is high is ignored. When both are raised together while idle, transmit wins and the receive arm is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable (slow tick) |
| tx_data | input | 8 | Byte to transmit, sampled when a start is accepted |
| tx_start | input | 1 | Request to send `tx_data` |
| rx_arm | input | 1 | Request to receive one byte |
| rx_in | input | 1 | Serial receive pin (asynchronous) |
| tx_out | output | 1 | Serial transmit pin, idles at 1 |
| busy | output | 1 | High while a frame is sent or a reception is armed |
| tx_done | output | 1 | One-clock pulse at the end of a transmit frame |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | One-clock pulse when `rx_data` is updated |

## Verification
The assertions assume that `tick_en` is a single-clock strobe at most once per clock. They also assume that the request inputs are only meaningful when sampled on a clock edge. The bench generates the tick from a divider and drives every input at the falling clock edge. It holds the receive line steady for whole bit periods of 27 ticks, so the mid-bit samples never land on a transition. Tick spacing is changed only while the channel is idle, before the rollover frames are started.

// File: rtl/tick_uart_pkg.sv
package tick_uart_pkg;
   typedef enum logic [1:0] {
      CH_IDLE    = 2'd0,
      CH_TX      = 2'd1,
      CH_RX_HUNT = 2'd2,
      CH_RX_BITS = 2'd3
   } ch_state_t;
endpackage

// File: rtl/tu_free_counter.sv
module tu_free_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (tick_en) count <= count + W'(1);
   end

   // R1: one step per tick, wrapping naturally
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> count == $past(count) + W'(1));
   a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count));
endmodule

// File: rtl/tu_sync.sv
module tu_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("tu_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tu_compare.sv
module tu_compare #(
   parameter int W    = 16,
   parameter int STEP = 27
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic [W-1:0] count,
   input  logic         armed,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         hit
);
   localparam logic [W-1:0] STEP_V = W'(STEP);
   localparam logic [W-1:0] GAP_V  = W'(STEP - 1);

   logic [W-1:0] cmp_q;

   assign hit = armed && tick_en && (count == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n)    cmp_q <= '0;
      else if (load) cmp_q <= load_val;
      else if (hit)  cmp_q <= cmp_q + STEP_V;
   end

   // R5: after a match the next match lies exactly one period ahead (mod 2^W)
   a_r5_next_match_ahead: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !load) |=> (W'(cmp_q - count) == GAP_V));
endmodule

// File: rtl/tu_channel.sv
module tu_channel
   import tick_uart_pkg::*;
#(
   parameter int W          = 16,
   parameter int DATA_W     = 8,
   parameter int BIT_TICKS  = 27,
   parameter int HALF_TICKS = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      count,
   input  logic              hit,
   input  logic              rx_s,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_start,
   input  logic              rx_arm,
   output logic              armed,
   output logic              load,
   output logic [W-1:0]      load_val,
   output logic              tx_out,
   output logic              busy,
   output logic              tx_done,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done
);
   localparam int FRAME = DATA_W + 2;
   localparam int CW    = $clog2(FRAME + 1);
   localparam logic [W-1:0] TX_LEAD = W'(BIT_TICKS);
   localparam logic [W-1:0] RX_LEAD = W'(BIT_TICKS + HALF_TICKS);

   ch_state_t          state;
   logic [FRAME-1:0]   tx_sh;
   logic [DATA_W-1:0]  rx_sh;
   logic [CW-1:0]      bits;
   logic               rx_prev;
   logic               fall;
   logic               take_tx;

   assign fall    = rx_prev && !rx_s;
   assign take_tx = (state == CH_IDLE) && tx_start;
   assign load    = take_tx || ((state == CH_RX_HUNT) && fall);
   assign load_val = count + (take_tx ? TX_LEAD : RX_LEAD);
   assign armed   = (state == CH_TX) || (state == CH_RX_BITS);
   assign busy    = (state != CH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= CH_IDLE;
         tx_sh   <= '0;
         rx_sh   <= '0;
         bits    <= '0;
         rx_prev <= 1'b1;
         tx_out  <= 1'b1;
         tx_done <= 1'b0;
         rx_done <= 1'b0;
         rx_data <= '0;
      end else begin
         tx_done <= 1'b0;
         rx_done <= 1'b0;
         rx_prev <= rx_s;
         case (state)
            CH_IDLE: begin
               if (tx_start) begin
                  tx_sh <= {1'b1, tx_data, 1'b0};
                  bits  <= CW'(FRAME);
                  state <= CH_TX;
               end else if (rx_arm) begin
                  state <= CH_RX_HUNT;
               end
            end
            CH_TX: begin
               if (hit) begin
                  if (bits == '0) begin
                     tx_out  <= 1'b1;
                     tx_done <= 1'b1;
                     state   <= CH_IDLE;
                  end else begin
                     tx_out <= tx_sh[0];
                     tx_sh  <= tx_sh >> 1;
                     bits   <= bits - CW'(1);
                  end
               end
            end
            CH_RX_HUNT: begin
               if (fall) begin
                  bits  <= CW'(DATA_W);
                  state <= CH_RX_BITS;
               end
            end
            CH_RX_BITS: begin
               if (hit) begin
                  rx_sh <= {rx_s, rx_sh[DATA_W-1:1]};
                  bits  <= bits - CW'(1);
                  if (bits == CW'(1)) begin
                     rx_data <= {rx_s, rx_sh[DATA_W-1:1]};
                     rx_done <= 1'b1;
                     state   <= CH_IDLE;
                  end
               end
            end
            default: state <= CH_IDLE;
         endcase
      end
   end

   // R2: the line rests at mark outside a transmit frame
   a_r2_mark_outside_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (state != CH_TX) |-> tx_out);
   // R3: the pin only moves on the edge of a compare match
   a_r3_edge_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_out) |-> $past(hit));
   // R6: completion is a single pulse and leaves the channel idle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (!busy && $past(hit)));
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);
   // R8: a received byte is only delivered on a sampling match
   a_r8_rx_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> ($past(hit) && !busy));
   // R10: requests during a transmit frame cannot arm reception
   a_r10_no_arm_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == CH_TX) && (tx_start || rx_arm)) |=> (state != CH_RX_HUNT));
   a_r10_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_done, rx_done}));
endmodule

// File: rtl/tick_uart.sv
module tick_uart #(
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 8,
   parameter int BIT_TICKS   = 27,
   parameter int HALF_TICKS  = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_start,
   input  logic              rx_arm,
   input  logic              rx_in,
   output logic              tx_out,
   output logic              busy,
   output logic              tx_done,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done
);
   generate
      if (HALF_TICKS >= BIT_TICKS || HALF_TICKS < 1) begin : g_bad_half
         $error("HALF_TICKS must lie between 1 and BIT_TICKS-1");
      end
      if (BIT_TICKS + HALF_TICKS >= 2 ** (CNT_W - 1)) begin : g_bad_bit
         $error("bit period too long for the counter width");
      end
   endgenerate

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] load_val;
   logic             hit, armed, load, rx_s;

   tu_free_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count));

   tu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s));

   tu_compare #(.W(CNT_W), .STEP(BIT_TICKS)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count),
      .armed(armed), .load(load), .load_val(load_val), .hit(hit));

   tu_channel #(
      .W(CNT_W), .DATA_W(DATA_W),
      .BIT_TICKS(BIT_TICKS), .HALF_TICKS(HALF_TICKS)
   ) u_ch (
      .clk(clk), .rst_n(rst_n), .count(count), .hit(hit), .rx_s(rx_s),
      .tx_data(tx_data), .tx_start(tx_start), .rx_arm(rx_arm),
      .armed(armed), .load(load), .load_val(load_val),
      .tx_out(tx_out), .busy(busy), .tx_done(tx_done),
      .rx_data(rx_data), .rx_done(rx_done));
endmodule

// File: tb/tick_uart_tb.sv
module tick_uart_tb;
   localparam int BIT  = 27;
   localparam int HALF = 14;

   typedef struct { logic [7:0] d; int t0; } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_start = 1'b0;
   logic       rx_arm = 1'b0;
   logic       rx_in = 1'b1;
   logic       tx_out, busy, tx_done, rx_done;
   logic [7:0] rx_data;

   int   tick_cnt = 0;
   int   tick_div = 2;
   int   div_cnt  = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   exp_t txq[$];
   exp_t rxq[$];

   tick_uart u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tx_data(tx_data),
      .tx_start(tx_start), .rx_arm(rx_arm), .rx_in(rx_in), .tx_out(tx_out),
      .busy(busy), .tx_done(tx_done), .rx_data(rx_data), .rx_done(rx_done));

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (div_cnt + 1 >= tick_div) begin div_cnt = 0; tick_en = 1'b1; end
      else begin div_cnt = div_cnt + 1; tick_en = 1'b0; end
   end

   always @(posedge clk) begin
      if (!rst_n)       tick_cnt <= 0;
      else if (tick_en) tick_cnt <= tick_cnt + 1;
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_tick(int t);
      while (tick_cnt < t) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // transmit driver: pushes expected byte and its accept count
   task automatic send_tx(logic [7:0] d);
      exp_t e;
      @(negedge clk);
      while (busy) @(negedge clk);
      e.d = d; e.t0 = tick_cnt;
      txq.push_back(e);
      tx_data = d; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      while (busy) @(negedge clk);
   endtask

   // receive driver: arms and plays one frame on rx_in
   task automatic send_rx(logic [7:0] d);
      exp_t e;
      logic [9:0] fr;
      int t;
      fr = {1'b1, d, 1'b0};
      @(negedge clk);
      while (busy) @(negedge clk);
      rx_arm = 1'b1;
      @(negedge clk);
      rx_arm = 1'b0;
      wait_tick(tick_cnt + 5);
      t = tick_cnt;
      e.d = d; e.t0 = t;
      rxq.push_back(e);
      for (int k = 0; k < 10; k++) begin
         wait_tick(t + BIT * k);
         rx_in = fr[k];
      end
      wait_tick(t + BIT * 10);
      rx_in = 1'b1;
   endtask

   // transmit monitor
   initial begin
      logic prev_tx;
      prev_tx = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && prev_tx && !tx_out) begin
            if (txq.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R10: actual unexpected frame expected none");
            end else begin
               exp_t e;
               logic [9:0] fr;
               int tf;
               e = txq.pop_front();
               fr = {1'b1, e.d, 1'b0};
               tf = tick_cnt;
               chk("R3 start bit tick", tf - e.t0, BIT + 1);
               for (int k = 0; k < 10; k++) begin
                  if (k > 0) begin
                     wait_tick(tf + BIT * k - 1);
                     chk("R5 level before edge", int'(tx_out), int'(fr[k-1]));
                     wait_tick(tf + BIT * k);
                     chk("R5 level after edge", int'(tx_out), int'(fr[k]));
                  end
                  wait_tick(tf + BIT * k + HALF - 1);
                  chk("R4 frame bit", int'(tx_out), int'(fr[k]));
               end
               while (!tx_done && tick_cnt < tf + 400) @(negedge clk);
               chk("R6 done tick", tick_cnt - e.t0, 11 * BIT + 1);
               chk("R6 busy low at done", int'(busy), 0);
               chk("R2 mark after frame", int'(tx_out), 1);
            end
         end
         prev_tx = tx_out;
      end
   end

   // receive monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rx_done) begin
            if (rxq.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R9: actual unexpected rx_done expected none");
            end else begin
               exp_t e;
               int dt;
               e = rxq.pop_front();
               dt = tick_cnt - e.t0;
               chk("R8 received byte", int'(rx_data), int'(e.d));
               chk("R7 done window", int'(dt >= BIT + HALF + 7 * BIT + 1 &&
                   dt <= BIT + HALF + 7 * BIT + 3), 1);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset tx_out", int'(tx_out), 1);
      chk("R2 reset busy", int'(busy), 0);
      chk("R2 reset tx_done", int'(tx_done), 0);
      chk("R2 reset rx_done", int'(rx_done), 0);
      chk("R2 reset rx_data", int'(rx_data), 0);

      send_tx(8'hA5);
      send_tx(8'h00);
      send_tx(8'hFF);
      send_tx(8'h55);

      send_rx(8'h3C);
      send_rx(8'h81);
      send_rx(8'h00);
      send_rx(8'hFF);
      send_rx(8'hC6);

      // R9: a transmit frame leaves the received byte alone
      send_tx(8'h18);
      chk("R9 rx_data held after tx", int'(rx_data), 8'hC6);
      // R9: line pulses while not armed are not captured
      @(negedge clk);
      rx_in = 1'b0;
      wait_tick(tick_cnt + 3 * BIT);
      rx_in = 1'b1;
      wait_tick(tick_cnt + 2 * BIT);
      chk("R9 rx_data held unarmed", int'(rx_data), 8'hC6);
      chk("R9 not busy unarmed", int'(busy), 0);

      // R10: requests while transmitting are dropped
      begin
         exp_t e;
         @(negedge clk);
         e.d = 8'h4B; e.t0 = tick_cnt;
         txq.push_back(e);
         tx_data = 8'h4B; tx_start = 1'b1;
         @(negedge clk);
         tx_start = 1'b0;
         wait_tick(tick_cnt + 3 * BIT);
         tx_data = 8'h11; tx_start = 1'b1; rx_arm = 1'b1;
         @(negedge clk);
         tx_start = 1'b0; rx_arm = 1'b0;
         while (busy) @(negedge clk);
         wait_tick(tick_cnt + 2 * BIT);
         chk("R10 busy low after dropped requests", int'(busy), 0);
      end

      // R10: simultaneous requests while idle, transmit wins
      begin
         exp_t e;
         @(negedge clk);
         e.d = 8'h69; e.t0 = tick_cnt;
         txq.push_back(e);
         tx_data = 8'h69; tx_start = 1'b1; rx_arm = 1'b1;
         @(negedge clk);
         tx_start = 1'b0; rx_arm = 1'b0;
         while (busy) @(negedge clk);
         wait_tick(tick_cnt + 2 * BIT);
         chk("R10 receive arm dropped", int'(busy), 0);
      end

      // R10: start request during reception is dropped
      fork
         send_rx(8'h2D);
         begin
            wait_tick(tick_cnt + 4 * BIT);
            tx_data = 8'hEE; tx_start = 1'b1;
            @(negedge clk);
            tx_start = 1'b0;
            chk("R10 tx_out idle during rx", int'(tx_out), 1);
         end
      join
      wait_tick(tick_cnt + BIT);

      // R1, R5: run to just short of counter rollover, then frames across it
      tick_div = 1;
      wait_tick(65500);
      tick_div = 2;
      send_tx(8'h96);
      send_rx(8'h5A);
      chk("R1 counter wrapped", int'(tick_cnt >= 65536), 1);
      wait_tick(tick_cnt + 2 * BIT);

      chk("R8 tx queue drained", txq.size(), 0);
      chk("R8 rx queue drained", rxq.size(), 0);
      summary();
      $finish;
   end
endmodule